// File: doc/BRIEF.md
# Quadratic Permutation Address Generator

This block generates the read order for the interleaving stage of a turbo-code encoder or decoder. For a block of K bits it emits, one per clock, the addresses P(i) = (f1·i + f2·i²) mod K for i = 0 to K−1. The coefficient pair (f1, f2) and the block length K are chosen outside the block and are presented on inputs together with a start pulse. Any legal block length from 40 to 6144 bits can be used, with no change to the logic. Each address comes with a valid flag, its index i, and a flag that marks the final index.

No multiplier or divider is used. The generator keeps three residues below K: the current address, the current first difference, and the constant second difference 2·f2 mod K. It advances the address by adding the first difference, and it advances the first difference by adding the second difference. Every sum of two residues is below 2K, so a single compare against K followed by one optional subtraction reduces it. This keeps the path short enough to produce one address on every cycle.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so the block is usable from the third rising edge after `rst_n` goes high.

Top module: `qpp_addr_gen`

## Requirements
- R1: For every valid output, `addr` equals (f1·i + f2·i²) mod K, where i is `addr_idx` and K, f1, f2 are the values sampled at the start. This holds for 40 ≤ K ≤ 6144, f1 < K and f2 < K.
- R2: For a legal coefficient set, the K addresses of one block are a permutation of 0..K−1, each value appearing exactly once.
- R3: Whenever `addr_vld` is 1, `addr` is below K.
- R4: A start sampled at a rising edge gives `addr_vld`=1, `addr_idx`=0 and `addr`=0 after that edge. `blk_len`, `lin_coef` and `quad_coef` are sampled only at that edge, and changing them later in the block has no effect on the outputs.
- R5: While a block runs, a new address appears on every clock and `addr_idx` rises by exactly 1 each cycle, with no gaps.
- R6: `addr_last` is 1 exactly on the cycle in which `addr_idx` equals K−1, and never on any other cycle.
- R7: After the cycle with `addr_last`=1, `addr_vld` is 0 and stays 0 until the next start.
- R8: A start that arrives during a block abandons that block. The sequence begins again from index 0 using the newly sampled K, f1 and f2.
- R9: During reset and after it, before any start, `addr_vld` and `addr_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| start | input | 1 | Begins a block; samples the three parameter inputs |
| blk_len | input | 13 | Block length K (40..6144) |
| lin_coef | input | 13 | Linear coefficient f1 (below K) |
| quad_coef | input | 13 | Quadratic coefficient f2 (below K) |
| addr_vld | output | 1 | Address on `addr` is valid |
| addr | output | 13 | Interleaved address P(i) |
| addr_idx | output | 13 | Index i of the current address |
| addr_last | output | 1 | Current address is the final one of the block (i = K−1) |

## Verification
The case that is hardest to reach is a single-subtraction reduction performed with operands close to K. This happens only in long blocks where the first difference has grown large. The stimulus therefore runs the full 6144-entry block as well as short ones, and it compares every address against a direct evaluation of the quadratic while tracking each block for duplicate addresses. Two further situations are awkward to set up from the ports. In the first, the parameter inputs change in the middle of a block. In the second, a restart interrupts a block a few cycles after it begins. The bench drives both on purpose and queues exactly the truncated prefix that should appear before the new sequence.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  // largest supported block length
  localparam int unsigned QPP_KMAX = 6144;
  // smallest supported block length
  localparam int unsigned QPP_KMIN = 40;
  // residue width able to hold 0..QPP_KMAX-1
  localparam int unsigned QPP_AW   = $clog2(QPP_KMAX);
endpackage

// File: rtl/qpp_rst_sync.sv
module qpp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/qpp_modadd.sv
// (a + b) mod k for a, b < k: a single compare and an optional subtract
module qpp_modadd #(
  parameter int AW = 13
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  input  logic [AW-1:0] k,
  output logic [AW-1:0] r
);
  logic [AW:0] sum;
  logic        wrap;

  always_comb begin
    sum  = {1'b0, a} + {1'b0, b};
    wrap = (sum >= {1'b0, k});
    r    = wrap ? AW'(sum - {1'b0, k}) : AW'(sum);
  end
endmodule

// File: rtl/qpp_recur.sv
// second-order recursion: address, first difference, second difference
module qpp_recur #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] k_in,
  input  logic [AW-1:0] f1_in,
  input  logic [AW-1:0] f2_in,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] k_held
);
  localparam int LANES = 2;

  logic [AW-1:0] a_q, g_q, d_q, k_q;
  logic [AW-1:0] a_d, g_d, d_d, k_d;
  logic [AW-1:0] g_init, d_init;
  logic          reg_en;

  // setup residues, computed from the raw inputs at load
  qpp_modadd #(.AW(AW)) u_g_init (.a(f1_in), .b(f2_in), .k(k_in), .r(g_init));
  qpp_modadd #(.AW(AW)) u_d_init (.a(f2_in), .b(f2_in), .k(k_in), .r(d_init));

  // step lanes: lane 0 advances the address, lane 1 the first difference
  logic [AW-1:0] lane_x [LANES];
  logic [AW-1:0] lane_y [LANES];
  logic [AW-1:0] lane_r [LANES];

  assign lane_x[0] = a_q;
  assign lane_y[0] = g_q;
  assign lane_x[1] = g_q;
  assign lane_y[1] = d_q;

  genvar ln;
  generate
    for (ln = 0; ln < LANES; ln++) begin : g_lane
      qpp_modadd #(.AW(AW)) u_step (
        .a(lane_x[ln]), .b(lane_y[ln]), .k(k_q), .r(lane_r[ln])
      );
    end
  endgenerate

  assign reg_en = load | step;

  always_comb begin
    a_d = a_q;
    g_d = g_q;
    d_d = d_q;
    k_d = k_q;
    if (load) begin
      a_d = '0;
      g_d = g_init;
      d_d = d_init;
      k_d = k_in;
    end else if (step) begin
      a_d = lane_r[0];
      g_d = lane_r[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      g_q <= '0;
      d_q <= '0;
      k_q <= '0;
    end else if (reg_en) begin
      a_q <= a_d;
      g_q <= g_d;
      d_q <= d_d;
      k_q <= k_d;
    end
  end

  assign addr   = a_q;
  assign k_held = k_q;

  // R4: a load always starts the address sequence at zero
  assert_zero_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (a_q == '0));

  // R3: the held operands stay reduced below the held length after a step
  assert_operand_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && (g_q < k_q) && (d_q < k_q) && (a_q < k_q))
      |=> ((a_q < k_q) && (g_q < k_q)));
endmodule

// File: rtl/qpp_seq_ctrl.sv
// index counter, valid and last-flag sequencing
module qpp_seq_ctrl #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] k_in,
  output logic          step_en,
  output logic          vld,
  output logic          last,
  output logic [AW-1:0] idx
);
  logic          vld_q, vld_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [AW-1:0] klast_q, klast_d;
  logic          at_end;
  logic          cnt_en;

  assign at_end = vld_q && (idx_q == klast_q);
  assign cnt_en = start | vld_q;

  always_comb begin
    vld_d   = vld_q;
    idx_d   = idx_q;
    klast_d = klast_q;
    if (start) begin
      vld_d   = 1'b1;
      idx_d   = '0;
      klast_d = k_in - AW'(1);
    end else if (vld_q) begin
      if (at_end) vld_d = 1'b0;
      else        idx_d = idx_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      idx_q   <= '0;
      klast_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (cnt_en) idx_q   <= idx_d;
      if (start)  klast_q <= klast_d;
    end
  end

  assign step_en = vld_q && !at_end;
  assign vld     = vld_q;
  assign last    = at_end;
  assign idx     = idx_q;

  // R4: start yields a valid first index on the next cycle
  assert_first_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vld_q && (idx_q == '0)));

  // R5: running block steps the index by one each cycle
  assert_index_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !at_end && !start) |=> (vld_q && (idx_q == $past(idx_q) + AW'(1))));

  // R7: valid drops after the final address
  assert_done_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !start) |=> !vld_q);

  // R7: idle stays idle without a start
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_q && !start) |=> !vld_q);
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen #(
  parameter  int KMAX = qpp_pkg::QPP_KMAX,
  localparam int AW   = $clog2(KMAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] blk_len,
  input  logic [AW-1:0] lin_coef,
  input  logic [AW-1:0] quad_coef,
  output logic          addr_vld,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] addr_idx,
  output logic          addr_last
);
  logic          rst_i_n;
  logic          step_en;
  logic [AW-1:0] k_held;

  qpp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  qpp_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .start   (start),
    .k_in    (blk_len),
    .step_en (step_en),
    .vld     (addr_vld),
    .last    (addr_last),
    .idx     (addr_idx)
  );

  qpp_recur #(.AW(AW)) u_recur (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .load   (start),
    .step   (step_en),
    .k_in   (blk_len),
    .f1_in  (lin_coef),
    .f2_in  (quad_coef),
    .addr   (addr),
    .k_held (k_held)
  );

  // R3: every emitted address is below the sampled block length
  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    addr_vld |-> (addr < k_held));

  // R6: the last flag only accompanies a valid address at index K-1
  assert_last_index_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    addr_last |-> (addr_vld && (addr_idx == k_held - AW'(1))));
endmodule

// File: tb/tb_qpp_addr_gen.sv
module tb_qpp_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int WATCHDOG = 150000;

  typedef struct {
    int addr;
    int idx;
    bit last;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] blk_len, lin_coef, quad_coef;
  logic          addr_vld, addr_last;
  logic [AW-1:0] addr, addr_idx;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  exp_t q[$];

  bit seen [0:8191];
  int seen_cnt = 0;
  bit dup_flag = 0;
  int cur_k = 0;

  qpp_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .blk_len(blk_len), .lin_coef(lin_coef), .quad_coef(quad_coef),
    .addr_vld(addr_vld), .addr(addr), .addr_idx(addr_idx), .addr_last(addr_last)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: queue the expected items for n indices of a block
  task automatic push_exp(input int k, input int f1, input int f2, input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      longint v;
      v = (longint'(f1) * i + longint'(f2) * i * i) % k;
      e.addr = int'(v);
      e.idx  = i;
      e.last = (i == k - 1);
      q.push_back(e);
    end
  endtask

  task automatic pulse(input int k, input int f1, input int f2);
    @(negedge clk);
    start <= 1'b1;
    blk_len <= AW'(k);
    lin_coef <= AW'(f1);
    quad_coef <= AW'(f2);
    @(negedge clk);
    start <= 1'b0;
  endtask

  task automatic wait_drain_and_idle(input int k);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(addr_vld == 1'b0, "R7 valid low after last", addr_vld, 0);
    repeat (3) @(negedge clk);
    check(addr_vld == 1'b0 && addr_last == 1'b0, "R7 stays idle", addr_vld, 0);
    check(seen_cnt == k && !dup_flag, "R2 permutation", seen_cnt, k);
  endtask

  task automatic run_full(input int k, input int f1, input int f2, input bit scramble);
    push_exp(k, f1, f2, k);
    pulse(k, f1, f2);
    if (scramble) begin
      // R4: parameter inputs change after the start; outputs must not follow
      blk_len <= AW'(41);
      lin_coef <= AW'(5);
      quad_coef <= AW'(17);
    end
    wait_drain_and_idle(k);
  endtask

  // monitor: compare each valid output with the head of the queue
  always @(negedge clk) begin
    if (rst_n && addr_vld && !finished) begin
      if (q.size() == 0) begin
        check(0, "R5 unexpected address", int'(addr_idx), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (e.idx == 0) begin
          for (int j = 0; j < 8192; j++) seen[j] = 0;
          seen_cnt = 0;
          dup_flag = 0;
        end
        check(int'(addr_idx) == e.idx, "R5 index", int'(addr_idx), e.idx);
        check(int'(addr) == e.addr, "R1 address", int'(addr), e.addr);
        check(addr_last == e.last, "R6 last flag", addr_last, e.last);
        if (seen[addr]) dup_flag = 1;
        seen[addr] = 1;
        seen_cnt++;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    start = 0;
    blk_len = '0;
    lin_coef = '0;
    quad_coef = '0;
    repeat (3) @(negedge clk);
    check(addr_vld == 1'b0 && addr_last == 1'b0, "R9 in reset", addr_vld, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(addr_vld == 1'b0 && addr_last == 1'b0, "R9 after reset", addr_vld, 0);

    run_full(40, 3, 10, 0);
    run_full(48, 7, 12, 1);
    run_full(56, 19, 42, 0);
    run_full(64, 7, 16, 0);
    run_full(72, 7, 18, 0);
    run_full(1024, 31, 64, 0);
    run_full(6144, 263, 480, 0);

    // R8: restart six addresses into a block with a different parameter set
    push_exp(6144, 263, 480, 6);
    push_exp(40, 3, 10, 40);
    pulse(6144, 263, 480);
    repeat (4) @(negedge clk);
    pulse(40, 3, 10);
    wait_drain_and_idle(40);
    check(q.size() == 0, "R8 restart queue drained", q.size(), 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule